// File: doc/BRIEF.md
# Dual-Phase Framed Serial Transmitter

This block turns parallel audio words into a serial bit stream on one data pin. It runs on a single system clock. The bit clock and the frame-sync line come in as plain inputs, and each one passes through a short synchronizer. One bit-clock edge, chosen by configuration, is the "drive edge". Each drive edge moves the transmitter by exactly one bit time. A frame is started by a frame-sync assertion. After a programmable delay, the block sends one or two phases. Each phase has its own word length and its own number of words.

Words enter through a one-entry holding register with a valid/ready handshake. Ready is raised whenever that register is empty, so the source always knows when the next word is wanted.

Two sticky flags report problems: a sync error and an underrun. Both are cleared by dropping the run input, which also holds the whole transmitter idle.

Top module: `fsx_tx`

## Requirements
- R1: While `tx_run` is low, and after reset, `sdo` is 0, `in_ready` is 0 and both flags are 0; the holding register and the last-sent word are emptied (the last-sent word is cleared to 0).
- R2: The word-length code is a 3-bit field: 0 = 8, 1 = 12, 2 = 16, 3 = 20, 4 = 24, and 5, 6 or 7 = 32 bits. Each word sits in the low bits of `in_data` and is sent most significant bit first.
- R3: `cfg[7:5]` gives the phase-1 word length and `cfg[14:8]` the phase-1 word count minus one. With `cfg[31]` clear, a frame is phase 1 only.
- R4: With `cfg[31]` set, phase 2 follows phase 1 directly. It uses length `cfg[23:21]` and word count minus one `cfg[30:24]`.
- R5: `cfg[17:16]` sets the number of bit times between the sync drive edge and the first data bit (0 to 3). `sdo` is 0 during those bit times.
- R6: `cfg[0]` = 0 makes the rising bit-clock edge the drive edge; `cfg[0]` = 1 makes it the falling edge. `sdo` changes only after a drive edge.
- R7: `cfg[1]` = 1 makes `fsync` active low. A frame starts on the first drive edge at which the sync is seen active after being inactive at the previous drive edge.
- R8: With `cfg[18]` clear, a sync start that arrives before the last bit of the current frame has been driven restarts the frame and sets the sticky `sync_err`.
- R9: With `cfg[18]` set, such an early sync start is ignored: the frame continues unchanged and `sync_err` stays 0.
- R10: When a word is needed and the holding register is empty, the last word sent is repeated and the sticky `underrun` flag is set.
- R11: Dropping `tx_run` clears `sync_err` and `underrun`.
- R12: Every word accepted on the handshake is sent exactly once, in acceptance order. After an accept, `in_ready` is low on the next cycle.
- R13: A sync start at the drive edge right after the last data bit of a frame begins a new frame without a sync error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_run | input | 1 | Transmitter enable; low holds idle and clears flags |
| cfg | input | 32 | Frame and polarity configuration word |
| bclk | input | 1 | Bit clock, sampled by the system clock |
| fsync | input | 1 | Frame-sync input, sampled by the system clock |
| in_valid | input | 1 | Source offers a word |
| in_data | input | SLOT_W | Offered word, right-aligned |
| in_ready | output | 1 | Holding register empty and block running |
| sdo | output | 1 | Serial data out |
| sync_err | output | 1 | Sticky early frame-sync flag |
| underrun | output | 1 | Sticky missing-word flag |

## Verification
The properties assume three things about the inputs. `cfg` stays constant while `tx_run` is high. The bit clock's half period is several system clocks long, so that every drive edge produces one tick. `fsync` changes only well away from drive edges.

The stimulus keeps to these conditions. Configuration is applied only while the transmitter is stopped. Each bit clock half lasts six system cycles. The sync line and the sampled data both move at the non-drive edge, as a receiver would see them. Under these conditions the flag properties and the `sdo` stability between ticks are meaningful.

// File: rtl/fsx_pkg.sv
package fsx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DLY  = 2'd1,
      ST_SHF  = 2'd2
   } fsx_st_t;

   localparam int CF_EDGE   = 0;
   localparam int CF_FSPOL  = 1;
   localparam int CF_L1_LO  = 5;
   localparam int CF_C1_LO  = 8;
   localparam int CF_DLY_LO = 16;
   localparam int CF_IGN    = 18;
   localparam int CF_L2_LO  = 21;
   localparam int CF_C2_LO  = 24;
   localparam int CF_TWO    = 31;

   localparam int CNT_W = 7;
   localparam int WORD_W = 32;

   // word length minus one, from a 3-bit code
   function automatic logic [4:0] len_m1(input logic [2:0] code);
      case (code)
         3'd0:    len_m1 = 5'd7;
         3'd1:    len_m1 = 5'd11;
         3'd2:    len_m1 = 5'd15;
         3'd3:    len_m1 = 5'd19;
         3'd4:    len_m1 = 5'd23;
         default: len_m1 = 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/fsx_sync.sv
module fsx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign lvl  = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~chain[STAGES];
   assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/fsx_hold.sv
module fsx_hold #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   output logic             in_ready,
   input  logic             pop,
   output logic             hold_v,
   output logic [WIDTH-1:0] hold_d
);
   assign in_ready = run & ~hold_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_d <= '0;
      end else if (!run) begin
         hold_v <= 1'b0;
      end else if (in_valid && in_ready) begin
         hold_v <= 1'b1;
         hold_d <= in_data;
      end else if (pop) begin
         hold_v <= 1'b0;
      end
   end
endmodule

// File: rtl/fsx_seq.sv
module fsx_seq
   import fsx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [31:0]       cfg,
   input  logic              tick,
   input  logic              fs_lvl,
   input  logic              hold_v,
   input  logic [WORD_W-1:0] hold_w,
   output logic              pop,
   output logic              sdo,
   output logic              sync_err,
   output logic              underrun
);
   fsx_st_t          st, nst;
   logic [1:0]       dc, ndc;
   logic [4:0]       bc, nbc;
   logic [CNT_W-1:0] wc, nwc;
   logic             ph2, nph2;
   logic [WORD_W-1:0] sh, nsh, last, nlast;
   logic             fsp, nfsp, nsdo;
   logic             err_set, udr_set, do_load, busy, fs_start;
   logic [4:0]       ld_m1;
   logic [WORD_W-1:0] word_src;

   logic [4:0]       len1_m1, len2_m1;
   logic [CNT_W-1:0] cnt1, cnt2;
   logic [1:0]       dly;
   logic             ign, two;
   logic             unused_cfg_bits;

   assign len1_m1 = len_m1(cfg[CF_L1_LO +: 3]);
   assign len2_m1 = len_m1(cfg[CF_L2_LO +: 3]);
   assign cnt1    = cfg[CF_C1_LO +: CNT_W];
   assign cnt2    = cfg[CF_C2_LO +: CNT_W];
   assign dly     = cfg[CF_DLY_LO +: 2];
   assign ign     = cfg[CF_IGN];
   assign two     = cfg[CF_TWO];
   assign unused_cfg_bits = ^{cfg[4:0], cfg[15], cfg[20:19]};

   assign word_src = hold_v ? hold_w : last;
   assign fs_start = fs_lvl & ~fsp;
   assign busy = (st != ST_IDLE) &&
                 !(st == ST_SHF && bc == 5'd0 && wc == '0 && (ph2 || !two));

   always_comb begin
      nst = st; ndc = dc; nbc = bc; nwc = wc; nph2 = ph2;
      nsh = sh; nlast = last; nfsp = fsp; nsdo = sdo;
      err_set = 1'b0; udr_set = 1'b0; pop = 1'b0;
      do_load = 1'b0; ld_m1 = len1_m1;
      if (tick) begin
         nfsp = fs_lvl;
         if (fs_start && (!busy || !ign)) begin
            err_set = busy;
            nph2    = 1'b0;
            nwc     = cnt1;
            if (dly == 2'd0) begin
               do_load = 1'b1;
               nst     = ST_SHF;
            end else begin
               ndc  = dly - 2'd1;
               nsdo = 1'b0;
               nst  = ST_DLY;
            end
         end else begin
            case (st)
               ST_IDLE: nsdo = 1'b0;
               ST_DLY: begin
                  if (dc == 2'd0) begin
                     do_load = 1'b1;
                     nst     = ST_SHF;
                  end else begin
                     ndc  = dc - 2'd1;
                     nsdo = 1'b0;
                  end
               end
               ST_SHF: begin
                  if (bc != 5'd0) begin
                     nbc  = bc - 5'd1;
                     nsdo = sh[bc - 5'd1];
                  end else if (wc != '0) begin
                     nwc     = wc - 1'b1;
                     do_load = 1'b1;
                     ld_m1   = ph2 ? len2_m1 : len1_m1;
                  end else if (!ph2 && two) begin
                     nph2    = 1'b1;
                     nwc     = cnt2;
                     do_load = 1'b1;
                     ld_m1   = len2_m1;
                  end else begin
                     nst  = ST_IDLE;
                     nsdo = 1'b0;
                  end
               end
               default: nst = ST_IDLE;
            endcase
         end
         if (do_load) begin
            nsh     = word_src;
            nlast   = word_src;
            nbc     = ld_m1;
            nsdo    = word_src[ld_m1];
            pop     = hold_v;
            udr_set = ~hold_v;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; dc <= '0; bc <= '0; wc <= '0; ph2 <= 1'b0;
         sh <= '0; last <= '0; fsp <= 1'b0; sdo <= 1'b0;
         sync_err <= 1'b0; underrun <= 1'b0;
      end else if (!run) begin
         st <= ST_IDLE; dc <= '0; bc <= '0; wc <= '0; ph2 <= 1'b0;
         sh <= '0; last <= '0; fsp <= 1'b0; sdo <= 1'b0;
         sync_err <= 1'b0; underrun <= 1'b0;
      end else begin
         st <= nst; dc <= ndc; bc <= nbc; wc <= nwc; ph2 <= nph2;
         sh <= nsh; last <= nlast; fsp <= nfsp; sdo <= nsdo;
         sync_err <= sync_err | err_set;
         underrun <= underrun | udr_set;
      end
   end
endmodule

// File: rtl/fsx_tx.sv
module fsx_tx
   import fsx_pkg::*;
#(
   parameter int SLOT_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_run,
   input  logic [31:0]       cfg,
   input  logic              bclk,
   input  logic              fsync,
   input  logic              in_valid,
   input  logic [SLOT_W-1:0] in_data,
   output logic              in_ready,
   output logic              sdo,
   output logic              sync_err,
   output logic              underrun
);
   localparam int TAIL_W = SLOT_W - WORD_W;

   if (SLOT_W < WORD_W) begin : g_bad_slot
      $error("fsx_tx: SLOT_W must be at least 32");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("fsx_tx: SYNC_STAGES must be at least 1");
   end

   logic bc_lvl, bc_rise, bc_fall;
   logic fs_raw, unused_fs_rise, unused_fs_fall;
   logic tick_w, fs_lvl_w, pop_w, hold_v_w;
   logic [SLOT_W-1:0] hold_d_w;
   logic [WORD_W-1:0] hold_word;
   logic unused_bclk_lvl;

   fsx_sync #(.STAGES(SYNC_STAGES)) u_bsync (
      .clk(clk), .rst_n(rst_n), .din(bclk),
      .lvl(bc_lvl), .rise(bc_rise), .fall(bc_fall)
   );
   fsx_sync #(.STAGES(SYNC_STAGES)) u_fsync (
      .clk(clk), .rst_n(rst_n), .din(fsync),
      .lvl(fs_raw), .rise(unused_fs_rise), .fall(unused_fs_fall)
   );

   assign unused_bclk_lvl = bc_lvl;
   assign tick_w   = cfg[CF_EDGE] ? bc_fall : bc_rise;
   assign fs_lvl_w = fs_raw ^ cfg[CF_FSPOL];

   fsx_hold #(.WIDTH(SLOT_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .run(tx_run),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .pop(pop_w), .hold_v(hold_v_w), .hold_d(hold_d_w)
   );

   if (TAIL_W > 0) begin : g_wide
      logic unused_tail;
      assign unused_tail = ^hold_d_w[SLOT_W-1:WORD_W];
      assign hold_word   = hold_d_w[WORD_W-1:0];
   end else begin : g_exact
      assign hold_word = hold_d_w[WORD_W-1:0];
   end

   fsx_seq u_seq (
      .clk(clk), .rst_n(rst_n), .run(tx_run), .cfg(cfg),
      .tick(tick_w), .fs_lvl(fs_lvl_w),
      .hold_v(hold_v_w), .hold_w(hold_word), .pop(pop_w),
      .sdo(sdo), .sync_err(sync_err), .underrun(underrun)
   );
endmodule

// File: rtl/fsx_tx_chk.sv
module fsx_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_run,
   input logic tick,
   input logic in_valid,
   input logic in_ready,
   input logic sdo,
   input logic sync_err,
   input logic underrun
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_run |=> !sdo); // R1
   AST_FLAGS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_run |=> (!sync_err && !underrun)); // R11
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_run && sync_err) |=> (sync_err || !tx_run)); // R8
   AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_run && underrun) |=> (underrun || !tx_run)); // R10
   AST_SDO_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_run && !tick) |=> $stable(sdo)); // R6
   AST_HOLD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready); // R12
endmodule

bind fsx_tx fsx_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_run(tx_run), .tick(tick_w),
   .in_valid(in_valid), .in_ready(in_ready), .sdo(sdo),
   .sync_err(sync_err), .underrun(underrun)
);

// File: tb/fsx_tx_tb.sv
module fsx_tx_tb;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, tx_run, bclk, fsync, in_valid, in_ready, sdo, sync_err, underrun;
   logic [31:0] cfg, in_data;

   fsx_tx u_dut (
      .clk(clk), .rst_n(rst_n), .tx_run(tx_run), .cfg(cfg), .bclk(bclk),
      .fsync(fsync), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .sdo(sdo), .sync_err(sync_err), .underrun(underrun)
   );

   int total = 0, bad = 0;
   bit fs_pat[512];
   bit smp[512];
   bit expv[512];
   logic [31:0] words[16];
   int nw = 0, feed_idx = 0;
   bit feed_en = 0;
   // configuration fields
   bit edge_sel, fspol, ign, two;
   int dly, c1, c2;
   int l1, l2;
   bit exp_err, exp_udr;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expct);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expct);
      end
   endtask

   function automatic int blen(input int code);
      case (code)
         0: return 8;
         1: return 12;
         2: return 16;
         3: return 20;
         4: return 24;
         default: return 32;
      endcase
   endfunction

   function automatic int frame_len();
      int n = dly + (c1 + 1) * blen(l1);
      if (two) n += (c2 + 1) * blen(l2);
      return n;
   endfunction

   // source of words
   initial begin
      in_valid = 1'b0;
      in_data  = '0;
      forever begin : feeder
         bit acc;
         @(negedge clk);
         acc = in_valid && in_ready;
         @(posedge clk);
         #1;
         if (acc) feed_idx++;
         if (feed_en && feed_idx < nw) begin
            in_valid = 1'b1;
            in_data  = words[feed_idx];
         end else begin
            in_valid = 1'b0;
         end
      end
   end

   // reference stream built from the requirements
   task automatic build_exp(input int n);
      int st = 0, dc = 0, bc = 0, wc = 0, k = 0, lm;
      bit ph2 = 0, fsp = 0, fss, bsy, ld, o = 0;
      logic [31:0] sh = '0, last = '0;
      exp_err = 0;
      exp_udr = 0;
      for (int t = 0; t < n; t++) begin
         fss = fs_pat[t] && !fsp;
         fsp = fs_pat[t];
         bsy = (st != 0) && !(st == 2 && bc == 0 && wc == 0 && (ph2 || !two));
         ld = 0;
         lm = blen(l1);
         if (fss && (!bsy || !ign)) begin
            if (bsy) exp_err = 1;
            ph2 = 0;
            wc = c1;
            if (dly == 0) begin ld = 1; st = 2; end
            else begin dc = dly - 1; o = 0; st = 1; end
         end else if (st == 0) begin
            o = 0;
         end else if (st == 1) begin
            if (dc == 0) begin ld = 1; st = 2; end
            else begin dc--; o = 0; end
         end else begin
            if (bc != 0) begin bc--; o = sh[bc]; end
            else if (wc != 0) begin wc--; ld = 1; lm = ph2 ? blen(l2) : blen(l1); end
            else if (!ph2 && two) begin ph2 = 1; wc = c2; ld = 1; lm = blen(l2); end
            else begin st = 0; o = 0; end
         end
         if (ld) begin
            if (k < nw) begin sh = words[k]; k++; end
            else begin sh = last; exp_udr = 1; end
            last = sh;
            bc = lm - 1;
            o = sh[bc];
         end
         expv[t] = o;
      end
   endtask

   task automatic run_ticks(input int n);
      bit d = edge_sel ? 1'b0 : 1'b1;
      for (int t = 0; t < n; t++) begin
         fsync = fs_pat[t] ^ fspol;
         repeat (6) @(negedge clk);
         bclk = d;
         repeat (6) @(negedge clk);
         smp[t] = sdo;
         bclk = ~d;
      end
      fsync = fspol;
   endtask

   task automatic run_test(input string req, input int n, input bit stop);
      int mism = 0, first = -1;
      cfg = {two, 7'(c2), 3'(l2), 2'b00, ign, 2'(dly), 1'b0, 7'(c1), 3'(l1),
             3'b000, fspol, edge_sel};
      bclk = edge_sel;
      fsync = fspol;
      feed_idx = 0;
      repeat (3) @(negedge clk);
      tx_run = 1'b1;
      feed_en = 1'b1;
      repeat (4) @(negedge clk);
      run_ticks(n);
      build_exp(n);
      for (int t = 0; t < n; t++)
         if (smp[t] !== expv[t]) begin
            mism++;
            if (first < 0) first = t;
         end
      check(mism == 0, req, "bit stream mismatches (first bit index in log)",
            mism, 0);
      if (mism != 0) $display("  first mismatching bit time %0d", first);
      check(sync_err === exp_err, req, "sync_err", int'(sync_err), int'(exp_err));
      check(underrun === exp_udr, req, "underrun", int'(underrun), int'(exp_udr));
      if (stop) begin
         tx_run = 1'b0;
         feed_en = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic clear_pat();
      for (int i = 0; i < 512; i++) fs_pat[i] = 0;
   endtask

   task automatic base_cfg();
      edge_sel = 0; fspol = 0; ign = 0; two = 0;
      dly = 1; c1 = 1; c2 = 0; l1 = 2; l2 = 2;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0a17));
      rst_n = 1'b0; tx_run = 1'b0; cfg = '0; bclk = 1'b0; fsync = 1'b0;
      repeat (5) @(negedge clk);
      // R1: reset state
      check(sdo === 1'b0, "R1", "sdo after reset", int'(sdo), 0);
      check(in_ready === 1'b0, "R1", "in_ready after reset", int'(in_ready), 0);
      check(sync_err === 1'b0 && underrun === 1'b0, "R1", "flags after reset",
            int'({sync_err, underrun}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 R3 R12: one phase, two 16-bit words, delay 1
      base_cfg(); clear_pat(); fs_pat[0] = 1;
      nw = 2; words[0] = 32'h0000_a5c3; words[1] = 32'h0000_3c96;
      run_test("R2 R3 R12", frame_len() + 4, 1);

      // R4: two phases, 2 x 8 bits then 1 x 20 bits, delay 0
      base_cfg(); two = 1; dly = 0; l1 = 0; c1 = 1; l2 = 3; c2 = 0;
      clear_pat(); fs_pat[2] = 1;
      nw = 3; words[0] = 32'h81; words[1] = 32'h7e; words[2] = 32'h000f_0a55;
      run_test("R4", frame_len() + 6, 1);

      // R5: delays 0, 2, 3
      for (int d = 0; d < 4; d++) begin
         if (d == 1) continue;
         base_cfg(); dly = d; c1 = 0; l1 = 0;
         clear_pat(); fs_pat[1] = 1;
         nw = 1; words[0] = 32'hb7;
         run_test("R5", frame_len() + 4, 1);
      end

      // R6 R7: falling drive edge, active-low sync, 12-bit words
      base_cfg(); edge_sel = 1; fspol = 1; l1 = 1; c1 = 2;
      clear_pat(); fs_pat[0] = 1;
      nw = 3; words[0] = 32'h0abc; words[1] = 32'h0531; words[2] = 32'h0fe0;
      run_test("R6 R7", frame_len() + 4, 1);

      // R8 then R11: early sync restarts frame and sets the error
      base_cfg(); c1 = 2;
      clear_pat(); fs_pat[0] = 1; fs_pat[10] = 1;
      nw = 6;
      for (int i = 0; i < 6; i++) words[i] = 32'h1111 * (i + 3);
      run_test("R8", 10 + frame_len() + 4, 0);
      tx_run = 1'b0; feed_en = 1'b0;
      repeat (3) @(negedge clk);
      check(sync_err === 1'b0 && underrun === 1'b0, "R11", "flags after run low",
            int'({sync_err, underrun}), 0);
      check(sdo === 1'b0 && in_ready === 1'b0, "R1", "sdo/in_ready while stopped",
            int'({sdo, in_ready}), 0);

      // R9: same early sync ignored
      base_cfg(); c1 = 2; ign = 1;
      clear_pat(); fs_pat[0] = 1; fs_pat[10] = 1;
      nw = 3;
      for (int i = 0; i < 3; i++) words[i] = 32'h2345 + 32'h1357 * i;
      run_test("R9", frame_len() + 4, 1);

      // R10: three words needed, one supplied
      base_cfg(); c1 = 2; l1 = 0;
      clear_pat(); fs_pat[0] = 1;
      nw = 1; words[0] = 32'h000000c9;
      run_test("R10", frame_len() + 4, 1);

      // R13: back-to-back frames
      base_cfg(); dly = 0; c1 = 0; l1 = 0;
      clear_pat(); fs_pat[0] = 1; fs_pat[8] = 1;
      nw = 2; words[0] = 32'h5a; words[1] = 32'hc3;
      run_test("R13", 24, 1);

      // R2: 32-bit word from an out-of-range code, and 24-bit words
      base_cfg(); l1 = 7; c1 = 0;
      clear_pat(); fs_pat[0] = 1;
      nw = 1; words[0] = 32'hd00d_f00d;
      run_test("R2", frame_len() + 4, 1);
      base_cfg(); l1 = 4; c1 = 1;
      clear_pat(); fs_pat[0] = 1;
      nw = 2; words[0] = 32'h00c0_ffee; words[1] = 32'h0012_3456;
      run_test("R2", frame_len() + 4, 1);

      // random mix covering R2 R3 R4 R5 R6 R7 R8 R9 R12
      for (int it = 0; it < 14; it++) begin
         base_cfg();
         edge_sel = 1'($urandom_range(0, 1));
         fspol = 1'($urandom_range(0, 1));
         ign = 1'($urandom_range(0, 1));
         two = 1'($urandom_range(0, 1));
         dly = $urandom_range(0, 3);
         c1 = $urandom_range(0, 2);
         c2 = $urandom_range(0, 2);
         l1 = $urandom_range(0, 7);
         l2 = $urandom_range(0, 7);
         clear_pat(); fs_pat[0] = 1;
         if ($urandom_range(0, 2) == 0) fs_pat[$urandom_range(4, 30)] = 1;
         nw = 12;
         for (int i = 0; i < 12; i++) words[i] = $urandom;
         run_test("R2 R3 R4 R5 R6 R7 R8 R9 R12", frame_len() + 36, 1);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule